// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Set-Associative TLB

This block turns 14-bit virtual byte addresses into 12-bit physical byte addresses, using 64-byte pages. A small set-associative translation lookaside buffer (TLB) answers most requests one cycle after they are accepted. When the TLB misses, the block reads a page table. The page table holds one entry per virtual page, in internal registers. A valid entry is refilled into the TLB. The block raises a fault for a page that is not resident. It raises a separate fault for a write to a page marked read-only, which is how a copy-on-write scheme gets its trap.

Software, or a fault handler outside this block, loads page table entries through a dedicated write port. Each entry holds a physical page number, a valid bit and a writable bit. Writing an entry drops any cached TLB copy of that page. A flush input clears every TLB entry at once.

The controller has two states. `ST_LOOKUP` accepts requests and probes the TLB. `ST_WALK` reads the page table for a missed request. The controller moves from `ST_LOOKUP` to `ST_WALK` when an accepted request misses. In every other case it stays in `ST_LOOKUP`. It always moves from `ST_WALK` back to `ST_LOOKUP` after one cycle.

Top module: `vat_xlate`

## Requirements
- R1: The page offset is virtual address bits [5:0]. It appears unchanged in physical address bits [5:0]. The virtual page number is virtual address bits [13:6]. The physical page number fills physical address bits [11:6].
- R2: The TLB set is chosen by virtual page number bits [1:0]. The stored tag is virtual page number bits [7:2]. A hit needs a valid entry in that set whose tag matches. On a hit, the response comes one cycle after the request is accepted, with `rsp_tlb_hit` high.
- R3: After a miss, `req_ready` is low for exactly one cycle. The response then comes two cycles after acceptance, with `rsp_tlb_hit` low.
- R4: A miss on a page whose page table entry is invalid gives `rsp_page_fault` high and `rsp_paddr` zero. Nothing is entered into the TLB.
- R5: A write to a page whose entry is not writable gives `rsp_prot_fault` high and `rsp_paddr` zero. This applies on both the hit path and the walk path. Reads of the same page translate normally.
- R6: A walk that finds a valid entry places it in the indexed TLB set, so the next access to that page hits.
- R7: A refill uses the lowest-numbered invalid way of the set. If the set is full, it evicts the way named by that set's round-robin pointer. The pointer resets to 0 and advances by one only on an eviction.
- R8: Writing a page table entry invalidates any TLB entry for that virtual page. A walk in the same cycle for that same page does not refill.
- R9: A cycle with `flush` high invalidates every TLB entry. Flush takes priority over a refill in the same cycle.
- R10: After reset, `req_ready` is high, `rsp_valid` is low, the TLB is empty and every page table entry is invalid.
- R11: Suppose virtual page 0x0F maps to physical page 0x0D. Then virtual address 0x03D4 (set 3, tag 0x03, offset 0x14) translates to 0x354.
- R12: While `rsp_valid` is low, all response fields are zero. A request presented while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all TLB entries |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 14 | Virtual byte address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 12 | Physical byte address, zero on a fault |
| rsp_tlb_hit | output | 1 | Response came from the TLB |
| rsp_page_fault | output | 1 | Page not resident |
| rsp_prot_fault | output | 1 | Write to a read-only page |
| pte_we | input | 1 | Page table entry write strobe |
| pte_vpn | input | 8 | Virtual page number of the entry written |
| pte_ppn | input | 6 | Physical page number to store |
| pte_valid | input | 1 | Entry is resident |
| pte_writable | input | 1 | Entry allows writes |

## Verification
The bench builds the block with its default parameters: 14/12-bit addresses, 64-byte pages, and 4 sets of 4 ways. Five pages that share set 0 therefore fill the set and force one eviction. Further accesses then step the round-robin pointer through its ways, which makes the replacement order observable through the `rsp_tlb_hit` flag. The 256-entry page table at these widths also lets the specific 0x03D4 to 0x354 translation be checked exactly.

// File: rtl/vat_pkg.sv
package vat_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_WALK   = 1'b1
    } xl_state_e;
endpackage

// File: rtl/vat_ptab.sv
module vat_ptab #(
    parameter int VPN_W = 8,
    parameter int PPN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_valid,
    input  logic             wr_writable,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic [PPN_W-1:0] rd_ppn,
    output logic             rd_valid,
    output logic             rd_writable
);
    localparam int DEPTH = 1 << VPN_W;

    logic [PPN_W-1:0] ppn_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] wrb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            wrb_q <= '0;
            for (int i = 0; i < DEPTH; i++) ppn_q[i] <= '0;
        end else if (wr_en) begin
            ppn_q[wr_vpn] <= wr_ppn;
            vld_q[wr_vpn] <= wr_valid;
            wrb_q[wr_vpn] <= wr_writable;
        end
    end

    assign rd_ppn      = ppn_q[rd_vpn];
    assign rd_valid    = vld_q[rd_vpn];
    assign rd_writable = wrb_q[rd_vpn];
endmodule

// File: rtl/vat_tlb.sv
module vat_tlb #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [$clog2(SETS)-1:0] lk_idx,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic                    lk_hit,
    output logic [PPN_W-1:0]        lk_ppn,
    output logic                    lk_writable,
    input  logic                    fill_en,
    input  logic [$clog2(SETS)-1:0] fill_idx,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [PPN_W-1:0]        fill_ppn,
    input  logic                    fill_writable,
    input  logic                    inv_en,
    input  logic [$clog2(SETS)-1:0] inv_idx,
    input  logic [TAG_W-1:0]        inv_tag
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [WAYS-1:0]  wrb_q [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];

    logic [WAY_W-1:0] victim;
    logic             have_free;

    // Lookup: at most one way matches because refill only follows a miss.
    always_comb begin
        lk_hit      = 1'b0;
        lk_ppn      = '0;
        lk_writable = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
                lk_hit      = 1'b1;
                lk_ppn      = ppn_q[lk_idx][w];
                lk_writable = wrb_q[lk_idx][w];
            end
        end
    end

    // Victim: lowest free way, else the set's round-robin pointer.
    always_comb begin
        victim    = rr_q[fill_idx];
        have_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[fill_idx][w]) begin
                victim    = WAY_W'(w);
                have_free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                wrb_q[s] <= '0;
                rr_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    ppn_q[s][w] <= '0;
                end
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (flush) begin
                        vld_q[s][w] <= 1'b0;
                    end else if (fill_en && IDX_W'(s) == fill_idx && WAY_W'(w) == victim) begin
                        vld_q[s][w] <= 1'b1;
                        tag_q[s][w] <= fill_tag;
                        ppn_q[s][w] <= fill_ppn;
                        wrb_q[s][w] <= fill_writable;
                    end else if (inv_en && IDX_W'(s) == inv_idx && tag_q[s][w] == inv_tag) begin
                        vld_q[s][w] <= 1'b0;
                    end
                end
            end
            if (fill_en && !flush && !have_free) begin
                rr_q[fill_idx] <= rr_q[fill_idx] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vat_ctrl.sv
module vat_ctrl
    import vat_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int OFF_W = 6,
    parameter int PPN_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  req_ready,
    input  logic                  tlb_hit,
    input  logic [PPN_W-1:0]      tlb_ppn,
    input  logic                  tlb_writable,
    input  logic [PPN_W-1:0]      pt_ppn,
    input  logic                  pt_valid,
    input  logic                  pt_writable,
    input  logic                  pte_we,
    input  logic [VA_W-OFF_W-1:0] pte_vpn,
    output logic [VA_W-OFF_W-1:0] walk_vpn,
    output logic                  fill_en,
    output logic                  rsp_valid,
    output logic [PPN_W+OFF_W-1:0] rsp_paddr,
    output logic                  rsp_tlb_hit,
    output logic                  rsp_page_fault,
    output logic                  rsp_prot_fault
);
    localparam int VPN_W = VA_W - OFF_W;

    xl_state_e        state_q, state_d;
    logic [OFF_W-1:0] walk_off;
    logic             walk_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (req_valid && !tlb_hit) state_d = ST_WALK;
            ST_WALK:   state_d = ST_LOOKUP;
        endcase
    end

    assign req_ready = (state_q == ST_LOOKUP);
    assign fill_en   = (state_q == ST_WALK) && pt_valid && !flush
                       && !(pte_we && pte_vpn == walk_vpn);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_tlb_hit    <= 1'b0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
            walk_vpn       <= '0;
            walk_off       <= '0;
            walk_write     <= 1'b0;
        end else begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_tlb_hit    <= 1'b0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
            unique case (state_q)
                ST_LOOKUP: begin
                    if (req_valid) begin
                        walk_vpn   <= req_vaddr[VA_W-1:OFF_W];
                        walk_off   <= req_vaddr[OFF_W-1:0];
                        walk_write <= req_write;
                        if (tlb_hit) begin
                            rsp_valid   <= 1'b1;
                            rsp_tlb_hit <= 1'b1;
                            if (req_write && !tlb_writable) rsp_prot_fault <= 1'b1;
                            else rsp_paddr <= {tlb_ppn, req_vaddr[OFF_W-1:0]};
                        end
                    end
                end
                ST_WALK: begin
                    rsp_valid <= 1'b1;
                    if (!pt_valid)                      rsp_page_fault <= 1'b1;
                    else if (walk_write && !pt_writable) rsp_prot_fault <= 1'b1;
                    else                                rsp_paddr <= {pt_ppn, walk_off};
                end
            endcase
        end
    end

    logic unused_w;
    assign unused_w = ^{VPN_W};
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate #(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_BYTES = 64,
    parameter int SETS       = 4,
    parameter int WAYS       = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 flush,
    input  logic                                 req_valid,
    input  logic                                 req_write,
    input  logic [VA_W-1:0]                      req_vaddr,
    output logic                                 req_ready,
    output logic                                 rsp_valid,
    output logic [PA_W-1:0]                      rsp_paddr,
    output logic                                 rsp_tlb_hit,
    output logic                                 rsp_page_fault,
    output logic                                 rsp_prot_fault,
    input  logic                                 pte_we,
    input  logic [VA_W-$clog2(PAGE_BYTES)-1:0]   pte_vpn,
    input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]   pte_ppn,
    input  logic                                 pte_valid,
    input  logic                                 pte_writable
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    logic             tlb_hit, tlb_wr, pt_v, pt_wr, fill_en;
    logic [PPN_W-1:0] tlb_ppn, pt_ppn;
    logic [VPN_W-1:0] walk_vpn;

    vat_tlb #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .lk_idx        (req_vaddr[OFF_W+IDX_W-1:OFF_W]),
        .lk_tag        (req_vaddr[VA_W-1:OFF_W+IDX_W]),
        .lk_hit        (tlb_hit),
        .lk_ppn        (tlb_ppn),
        .lk_writable   (tlb_wr),
        .fill_en       (fill_en),
        .fill_idx      (walk_vpn[IDX_W-1:0]),
        .fill_tag      (walk_vpn[VPN_W-1:IDX_W]),
        .fill_ppn      (pt_ppn),
        .fill_writable (pt_wr),
        .inv_en        (pte_we),
        .inv_idx       (pte_vpn[IDX_W-1:0]),
        .inv_tag       (pte_vpn[VPN_W-1:IDX_W])
    );

    vat_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (pte_we),
        .wr_vpn      (pte_vpn),
        .wr_ppn      (pte_ppn),
        .wr_valid    (pte_valid),
        .wr_writable (pte_writable),
        .rd_vpn      (walk_vpn),
        .rd_ppn      (pt_ppn),
        .rd_valid    (pt_v),
        .rd_writable (pt_wr)
    );

    vat_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_vaddr      (req_vaddr),
        .req_ready      (req_ready),
        .tlb_hit        (tlb_hit),
        .tlb_ppn        (tlb_ppn),
        .tlb_writable   (tlb_wr),
        .pt_ppn         (pt_ppn),
        .pt_valid       (pt_v),
        .pt_writable    (pt_wr),
        .pte_we         (pte_we),
        .pte_vpn        (pte_vpn),
        .walk_vpn       (walk_vpn),
        .fill_en        (fill_en),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_tlb_hit    (rsp_tlb_hit),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault)
    );
endmodule

// File: rtl/vat_xlate_chk.sv
module vat_xlate_chk #(
    parameter int PA_W  = 12,
    parameter int OFF_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic [OFF_W-1:0] req_off,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_tlb_hit,
    input logic             rsp_page_fault,
    input logic             rsp_prot_fault
);
    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_hit && !rsp_prot_fault |-> rsp_paddr[OFF_W-1:0] == $past(req_off));

    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_hit |-> $past(req_valid && req_ready));

    // R3
    walk_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready && rsp_valid && !rsp_tlb_hit);

    // R3
    walk_resp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_tlb_hit |-> $past(!req_ready));

    // R4
    page_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_page_fault |-> rsp_valid && rsp_paddr == '0 && !rsp_tlb_hit && !rsp_prot_fault);

    // R5
    prot_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_fault |-> rsp_valid && rsp_paddr == '0);

    // R9
    flush_kills_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_hit |-> !$past(flush, 2));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_paddr == '0 && !rsp_tlb_hit && !rsp_page_fault && !rsp_prot_fault);
endmodule

bind vat_xlate vat_xlate_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .req_valid      (req_valid),
    .req_off        (req_vaddr[OFF_W-1:0]),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_tlb_hit    (rsp_tlb_hit),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault)
);

// File: tb/vat_xlate_tb.sv
module vat_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [11:0] rsp_paddr;
    logic        rsp_tlb_hit, rsp_page_fault, rsp_prot_fault;
    logic        pte_we = 1'b0;
    logic [7:0]  pte_vpn = '0;
    logic [5:0]  pte_ppn = '0;
    logic        pte_valid = 1'b0;
    logic        pte_writable = 1'b0;

    vat_xlate u_dut (.*);

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";

    // Behavioural model state
    bit       m_walk;
    bit [7:0] m_wvpn;
    bit [5:0] m_woff;
    bit       m_wwrite;
    bit [5:0] mt_tag [4][4];
    bit [5:0] mt_ppn [4][4];
    bit       mt_v   [4][4];
    bit       mt_wr  [4][4];
    int       mt_rr  [4];
    bit [5:0] pt_ppn [256];
    bit       pt_v   [256];
    bit       pt_wr  [256];
    bit        e_valid, e_hit, e_pf, e_prot;
    bit [11:0] e_pa;

    task automatic compare();
        checks++;
        if (req_ready !== !m_walk || rsp_valid !== e_valid || rsp_tlb_hit !== e_hit ||
            rsp_page_fault !== e_pf || rsp_prot_fault !== e_prot || rsp_paddr !== e_pa) begin
            errors++;
            $display("FAIL %s: actual rdy=%0b v=%0b hit=%0b pf=%0b prot=%0b pa=%03h expected rdy=%0b v=%0b hit=%0b pf=%0b prot=%0b pa=%03h",
                     cur_req, req_ready, rsp_valid, rsp_tlb_hit, rsp_page_fault, rsp_prot_fault, rsp_paddr,
                     !m_walk, e_valid, e_hit, e_pf, e_prot, e_pa);
        end
    endtask

    task automatic model_update();
        bit       do_fill = 0;
        bit [7:0] vpn;
        int       s, victim;
        bit       hit;
        int       hw;
        bit       nwalk = m_walk;
        e_valid = 0; e_hit = 0; e_pf = 0; e_prot = 0; e_pa = '0;
        if (!m_walk) begin
            if (req_valid) begin
                vpn = req_vaddr[13:6];
                s = int'(vpn[1:0]);
                hit = 0; hw = 0;
                for (int w = 0; w < 4; w++)
                    if (mt_v[s][w] && mt_tag[s][w] == vpn[7:2]) begin hit = 1; hw = w; end
                m_wvpn = vpn; m_woff = req_vaddr[5:0]; m_wwrite = req_write;
                if (hit) begin
                    e_valid = 1; e_hit = 1;
                    if (req_write && !mt_wr[s][hw]) e_prot = 1;
                    else e_pa = {mt_ppn[s][hw], req_vaddr[5:0]};
                end else nwalk = 1;
            end
        end else begin
            e_valid = 1;
            if (!pt_v[m_wvpn]) e_pf = 1;
            else if (m_wwrite && !pt_wr[m_wvpn]) e_prot = 1;
            else e_pa = {pt_ppn[m_wvpn], m_woff};
            do_fill = pt_v[m_wvpn] && !flush && !(pte_we && pte_vpn == m_wvpn);
            nwalk = 0;
        end
        victim = 0;
        if (do_fill) begin
            s = int'(m_wvpn[1:0]);
            victim = -1;
            for (int w = 0; w < 4; w++) if (!mt_v[s][w] && victim < 0) victim = w;
            if (victim < 0) begin victim = mt_rr[s]; mt_rr[s] = (mt_rr[s] + 1) % 4; end
        end
        if (flush) begin
            for (int a = 0; a < 4; a++) for (int w = 0; w < 4; w++) mt_v[a][w] = 0;
        end else begin
            if (pte_we)
                for (int w = 0; w < 4; w++)
                    if (mt_tag[pte_vpn[1:0]][w] == pte_vpn[7:2]) mt_v[pte_vpn[1:0]][w] = 0;
            if (do_fill) begin
                s = int'(m_wvpn[1:0]);
                mt_v[s][victim] = 1; mt_tag[s][victim] = m_wvpn[7:2];
                mt_ppn[s][victim] = pt_ppn[m_wvpn]; mt_wr[s][victim] = pt_wr[m_wvpn];
            end
        end
        if (pte_we) begin
            pt_ppn[pte_vpn] = pte_ppn; pt_v[pte_vpn] = pte_valid; pt_wr[pte_vpn] = pte_writable;
        end
        m_walk = nwalk;
    endtask

    task automatic step(input bit v, input bit w, input bit [13:0] va, input bit fl,
                        input bit pwe, input bit [7:0] pvpn, input bit [5:0] pppn,
                        input bit pv, input bit pwr);
        @(negedge clk);
        compare();
        req_valid = v; req_write = w; req_vaddr = va; flush = fl;
        pte_we = pwe; pte_vpn = pvpn; pte_ppn = pppn; pte_valid = pv; pte_writable = pwr;
        model_update();
    endtask

    task automatic idle();                        step(0, 0, '0, 0, 0, '0, '0, 0, 0); endtask
    task automatic acc(input bit w, input bit [13:0] va); step(1, w, va, 0, 0, '0, '0, 0, 0); endtask
    task automatic pte(input bit [7:0] vpn, input bit [5:0] ppn, input bit v, input bit wr);
        step(0, 0, '0, 0, 1, vpn, ppn, v, wr);
    endtask
    // access and let any walk finish
    task automatic touch(input bit w, input bit [13:0] va);
        acc(w, va); idle(); idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_walk = 0;
        for (int a = 0; a < 4; a++) begin
            mt_rr[a] = 0;
            for (int w = 0; w < 4; w++) begin mt_v[a][w] = 0; mt_tag[a][w] = 0; mt_ppn[a][w] = 0; mt_wr[a][w] = 0; end
        end
        for (int i = 0; i < 256; i++) begin pt_v[i] = 0; pt_wr[i] = 0; pt_ppn[i] = 0; end
        e_valid = 0; e_hit = 0; e_pf = 0; e_prot = 0; e_pa = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R10"; idle(); idle(); touch(0, 14'h03D4);
        cur_req = "R4";  touch(1, 14'h1234); touch(0, 14'h03D4);
        cur_req = "R11"; pte(8'h0F, 6'h0D, 1, 1); touch(0, 14'h03D4);
        cur_req = "R2";  touch(0, 14'h03D4); acc(0, 14'h03C0); acc(1, 14'h03FF); idle(); idle();
        cur_req = "R1";  touch(0, 14'h03C0); touch(1, 14'h03FF);
        cur_req = "R5";  pte(8'h20, 6'h05, 1, 0); touch(1, 14'h082A); touch(0, 14'h082A); touch(1, 14'h0800);
        cur_req = "R3";  pte(8'h31, 6'h11, 1, 1); acc(0, 14'h0C45); acc(0, 14'h0C46); acc(0, 14'h0C47); idle(); idle();
        cur_req = "R12"; acc(0, 14'h3FFF); acc(1, 14'h03D4); idle(); idle();
        cur_req = "R6";
        for (int i = 0; i < 5; i++) pte(8'(i * 4), 6'(i + 1), 1, 1);
        for (int i = 0; i < 5; i++) touch(0, {8'(i * 4), 6'h07});
        cur_req = "R7";
        for (int i = 0; i < 5; i++) touch(0, {8'(i * 4), 6'h01});
        touch(0, 14'h0009); touch(0, 14'h0109); touch(0, 14'h0409);
        cur_req = "R8";  pte(8'h10, 6'h3F, 1, 1); touch(0, 14'h0402); touch(0, 14'h0402);
        acc(0, 14'h0C80); step(0, 0, '0, 0, 1, 8'h32, 6'h22, 1, 1); idle(); touch(0, 14'h0C80); touch(0, 14'h0C80);
        cur_req = "R9";  step(0, 0, '0, 1, 0, '0, '0, 0, 0); touch(0, 14'h03D4); touch(0, 14'h03D4);
        acc(0, 14'h0C44); step(0, 0, '0, 1, 0, '0, '0, 0, 0); idle(); touch(0, 14'h0C44);
        idle(); idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule